// File: doc/BRIEF.md
# Word-Addressed Program Counter

This block holds the instruction fetch address of a simple non-pipelined processor and chooses the address of the next instruction. The address counts whole instruction words, so moving to the next instruction adds one. Its registered output drives the instruction memory address directly, with no further logic.

The controller decodes each instruction, takes part in a two-cycle instruction sequence and pulses an update strobe once per instruction. With the strobe it gives a mode code: step to the next word, take a conditional branch, jump to an absolute index, jump to a register value, or hold (stall). A branch comparison done elsewhere supplies a taken flag. The block also gives the current address plus one, which the controller writes into the link register on a jump-and-link.

Top module: `word_pc_unit`

## Requirements
- R1: While `rst_n` is low, `pc_q` is 0. The first update after reset starts from 0.
- R2: At a rising clock edge with `upd_en` low, `pc_q` keeps its value whatever the mode and data inputs are.
- R3: Mode code 0 (step), with `upd_en` high, loads `pc_q + 1` modulo 2^32. Stepping from 0xFFFFFFFF gives 0.
- R4: Mode code 1 (branch) with `br_taken` high loads `pc_q + 1 + br_off` modulo 2^32. `br_off` is a two's-complement word offset, so a branch at 3 with offset 3 goes to 7.
- R5: Mode code 1 with `br_taken` low loads `pc_q + 1`.
- R6: Mode code 2 (absolute jump) loads `jmp_idx` zero-extended to 32 bits.
- R7: Mode code 3 (register jump) loads `reg_val` unchanged.
- R8: Mode code 4 (hold) and the unused codes 5, 6 and 7 leave `pc_q` unchanged even when `upd_en` is high.
- R9: `br_taken` has no effect in any mode other than code 1.
- R10: `pc_inc` always equals `pc_q + 1` modulo 2^32, including 0 after 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| upd_en | input | 1 | Update strobe from the controller, one cycle per instruction |
| nxt_mode | input | 3 | Next-address mode code (0 step, 1 branch, 2 jump, 3 register jump, 4–7 hold) |
| br_taken | input | 1 | Result of the branch comparison |
| br_off | input | 32 | Sign-extended branch offset in words |
| jmp_idx | input | 26 | Absolute jump index in words |
| reg_val | input | 32 | Register value for register jump |
| pc_q | output | 32 | Current instruction word address |
| pc_inc | output | 32 | Current address plus one (link value) |

## Verification
Two things can come together at the same edge: the branch condition and a mode that must ignore it. Also, a redirecting mode code can come at the same edge where the update strobe is low. The bench drives every mode code, with the taken flag both ways and the strobe both ways, from a sweep of start addresses, offsets, indices and register values. After each edge it compares the address with a value it works out itself from these rules. The wrap at the top of the address space is reached through a register jump to 0xFFFFFFFF and then a step or a forward branch.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
  localparam int WPC_W = 32;

  typedef enum logic [2:0] {
    MODE_STEP   = 3'd0,
    MODE_BRANCH = 3'd1,
    MODE_JUMP   = 3'd2,
    MODE_REGJMP = 3'd3,
    MODE_HOLD   = 3'd4
  } wpc_mode_e;

  function automatic logic [WPC_W-1:0] f_step(input logic [WPC_W-1:0] pc);
    return pc + {{(WPC_W-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic [WPC_W-1:0] f_branch(input logic [WPC_W-1:0] pc,
                                                input logic [WPC_W-1:0] off);
    return f_step(pc) + off;
  endfunction
endpackage

// File: rtl/wpc_next.sv
module wpc_next
  import wpc_pkg::*;
#(
  parameter int PC_W  = WPC_W,
  parameter int IDX_W = 26
) (
  input  logic [2:0]      mode,
  input  logic            taken,
  input  logic [PC_W-1:0] pc,
  input  logic [PC_W-1:0] off,
  input  logic [IDX_W-1:0] idx,
  input  logic [PC_W-1:0] rv,
  output logic [PC_W-1:0] nxt,
  output logic [PC_W-1:0] seq,
  output logic            keep
);
  localparam int PAD_W = PC_W - IDX_W;

  logic [PC_W-1:0] jtarget;

  generate
    if (PAD_W > 0) begin : g_pad
      assign jtarget = {{PAD_W{1'b0}}, idx};
    end else begin : g_trunc
      assign jtarget = idx[PC_W-1:0];
    end
  endgenerate

  assign seq = f_step(pc);

  always_comb begin
    keep = 1'b0;
    nxt  = pc;
    case (mode)
      MODE_STEP:   nxt = seq;
      MODE_BRANCH: nxt = taken ? f_branch(pc, off) : seq;
      MODE_JUMP:   nxt = jtarget;
      MODE_REGJMP: nxt = rv;
      default:     keep = 1'b1;
    endcase
  end
endmodule

// File: rtl/wpc_reg.sv
module wpc_reg #(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [PC_W-1:0] d,
  output logic [PC_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end

  AST_NO_LOAD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q)); // R2
endmodule

// File: rtl/word_pc_unit.sv
module word_pc_unit
  import wpc_pkg::*;
#(
  parameter int PC_W  = WPC_W,
  parameter int IDX_W = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_en,
  input  logic [2:0]       nxt_mode,
  input  logic             br_taken,
  input  logic [PC_W-1:0]  br_off,
  input  logic [IDX_W-1:0] jmp_idx,
  input  logic [PC_W-1:0]  reg_val,
  output logic [PC_W-1:0]  pc_q,
  output logic [PC_W-1:0]  pc_inc
);
  logic [PC_W-1:0] nxt_pc;
  logic [PC_W-1:0] seq_pc;
  logic            mode_keep;
  logic            evt_load;
  logic            evt_take;
  logic            evt_regjmp;
  logic            evt_hold;

  wpc_next #(.PC_W(PC_W), .IDX_W(IDX_W)) u_next (
    .mode (nxt_mode),
    .taken(br_taken),
    .pc   (pc_q),
    .off  (br_off),
    .idx  (jmp_idx),
    .rv   (reg_val),
    .nxt  (nxt_pc),
    .seq  (seq_pc),
    .keep (mode_keep)
  );

  assign evt_load   = upd_en && !mode_keep;
  assign evt_take   = upd_en && (nxt_mode == MODE_BRANCH) && br_taken;
  assign evt_regjmp = upd_en && (nxt_mode == MODE_REGJMP);
  assign evt_hold   = upd_en && mode_keep;

  wpc_reg #(.PC_W(PC_W)) u_reg (
    .clk  (clk),
    .rst_n(rst_n),
    .load (evt_load),
    .d    (nxt_pc),
    .q    (pc_q)
  );

  assign pc_inc = seq_pc;

  AST_RESET_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> pc_q == '0); // R1
  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && nxt_mode == 3'd0) |=> pc_q == $past(pc_q) + 1'b1); // R3
  AST_BRANCH_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    evt_take |=> pc_q == $past(pc_q) + 1'b1 + $past(br_off)); // R4
  AST_REGJMP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    evt_regjmp |=> pc_q == $past(reg_val)); // R7
  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_hold |=> $stable(pc_q)); // R8
  AST_LINK_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $past(pc_inc) == pc_q || !$past(evt_load) || $past(nxt_mode) != 3'd0); // R10
endmodule

// File: tb/word_pc_unit_bench.sv
module word_pc_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        upd_en = 1'b0;
  logic [2:0]  nxt_mode = 3'd0;
  logic        br_taken = 1'b0;
  logic [31:0] br_off = '0;
  logic [25:0] jmp_idx = '0;
  logic [31:0] reg_val = '0;
  logic [31:0] pc_q;
  logic [31:0] pc_inc;

  int n_vec = 0;
  int n_bad = 0;
  logic [31:0] model_pc = '0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #2.5 clk = ~clk;

  word_pc_unit u_word_pc_unit (
    .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .nxt_mode(nxt_mode),
    .br_taken(br_taken), .br_off(br_off), .jmp_idx(jmp_idx),
    .reg_val(reg_val), .pc_q(pc_q), .pc_inc(pc_inc)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string tag_of(input logic u, input logic [2:0] m, input logic t);
    if (!u) return "R2";
    if (m == 3'd0) return t ? "R9/R3" : "R3";
    if (m == 3'd1) return t ? "R4" : "R5";
    if (m == 3'd2) return t ? "R9/R6" : "R6";
    if (m == 3'd3) return t ? "R9/R7" : "R7";
    return "R8";
  endfunction

  task automatic step(input logic u, input logic [2:0] m, input logic t,
                      input logic [31:0] off, input logic [25:0] idx, input logic [31:0] rv);
    @(negedge clk);
    upd_en = u; nxt_mode = m; br_taken = t; br_off = off; jmp_idx = idx; reg_val = rv;
    if (u) begin
      case (m)
        3'd0: model_pc = model_pc + 32'd1;
        3'd1: model_pc = t ? model_pc + 32'd1 + off : model_pc + 32'd1;
        3'd2: model_pc = {6'd0, idx};
        3'd3: model_pc = rv;
        default: ;
      endcase
    end
    @(posedge clk);
    #1;
    check(tag_of(u, m, t), pc_q, model_pc);
    check("R10", pc_inc, model_pc + 32'd1);
  endtask

  function automatic logic [31:0] nxt_lfsr(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", pc_q, 32'd0);
    check("R1", pc_inc, 32'd1);
    rst_n = 1'b1;
    model_pc = '0;
    for (int i = 0; i < 4; i++) step(1'b1, 3'd0, 1'b0, '0, '0, '0);
    step(1'b1, 3'd3, 1'b0, '0, '0, 32'd3);
    step(1'b1, 3'd1, 1'b1, 32'd3, '0, '0);
    check("R4", pc_q, 32'd7);
    step(1'b1, 3'd1, 1'b1, 32'hFFFF_FFF8, '0, '0);
    check("R4", pc_q, 32'd0);
    step(1'b1, 3'd3, 1'b0, '0, '0, 32'hFFFF_FFFF);
    check("R10", pc_inc, 32'd0);
    step(1'b1, 3'd0, 1'b0, '0, '0, '0);
    check("R3", pc_q, 32'd0);
    step(1'b1, 3'd3, 1'b0, '0, '0, 32'hFFFF_FFFE);
    step(1'b1, 3'd1, 1'b1, 32'd5, '0, '0);
    check("R4", pc_q, 32'd4);
    step(1'b1, 3'd2, 1'b1, '0, 26'h3FF_FFFF, 32'hDEAD_BEEF);
    check("R6", pc_q, 32'h03FF_FFFF);
    for (int m = 0; m < 8; m++)
      for (int t = 0; t < 2; t++)
        for (int u = 0; u < 2; u++)
          for (int k = 0; k < 12; k++) begin
            lfsr = nxt_lfsr(lfsr);
            step(u[0], m[2:0], t[0],
                 (k % 3 == 0) ? {{16{lfsr[15]}}, lfsr[15:0]} : {{24{lfsr[7]}}, lfsr[7:0]},
                 lfsr[31:6], nxt_lfsr(lfsr));
          end
    for (int k = 0; k < 1500; k++) begin
      lfsr = nxt_lfsr(lfsr);
      step(lfsr[3], lfsr[2:0], lfsr[4], {{16{lfsr[20]}}, lfsr[20:5]},
           lfsr[30:5], {lfsr[15:0], lfsr[31:16]});
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule